// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block takes stereo PCM audio arriving on a three-wire serial link and turns it into parallel samples. The three wires are a bit clock, a data line and a word clock that tells left from right. The block runs on a system clock that is much faster than the bit clock. It watches all three wires in that domain and treats each rising edge of the bit clock as one received bit. Each time the word clock changes level, the word that has just finished is given out on a 20-bit sample bus, together with a one-cycle strobe for the channel it belongs to.

A three-bit configuration port selects how the bits are read:

- **Resolution**: 16 or 20 bits.
- **Framing**: right-justified MSB-first, where the word sits at the end of each word-clock half, or an I2S-style 16-bit framing. In I2S framing the MSB follows the word-clock change by one bit clock, and each word occupies 32 bit clocks.
- **Polarity**: which word-clock level means "left".

The I2S framing is only allowed with 16-bit words. When 20 bits are selected, right-justified framing is used whatever the framing bit says. A 16-bit sample is sign-extended to the full 20-bit bus.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset the sample bus is zero and both strobes are low. No strobe is raised until one full word has been received after the first word-clock transition seen since reset.
- R2: With cfg = 3'b000, the 16 bits sampled on the last 16 bit-clock rising edges before a word-clock transition form the sample, MSB first. The sample is sign-extended from bit 15 to 20 bits. In this setting, word clock high means left and low means right.
- R3: With cfg[0] = 1 (20-bit), the 20 bits sampled on the last 20 rising edges before a transition form the sample, MSB first, with no extension.
- R4: In right-justified framing, bits received earlier in the half period than the last N bits have no effect on the sample.
- R5: With cfg[1] = 1 (I2S) and cfg[0] = 0, the rising edge that sees the word-clock change carries no data. The next 16 rising edges carry the word, MSB first. Any later bits in that half are ignored. The word is emitted at the following word-clock change and is sign-extended.
- R6: With cfg[0] = 1 and cfg[1] = 1, the block uses 20-bit right-justified framing.
- R7: With cfg[2] = 1, the channel mapping is swapped: word clock low means left and high means right.
- R8: Each completed word raises exactly one of valid_left and valid_right, for exactly one system clock. The two strobes are never high together.
- R9: Data is taken only at bit-clock rising edges. A change on sdata while the bit clock is high does not alter the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk | input | 1 | Serial bit clock, synchronous to clk |
| sdata | input | 1 | Serial data line |
| wclk | input | 1 | Word clock that selects the channel |
| cfg | input | 3 | Configuration: bit 0 selects 20-bit, bit 1 selects I2S framing, bit 2 swaps channel polarity |
| sample | output | 20 | Last received sample, sign-extended; held between strobes |
| valid_left | output | 1 | One-cycle strobe: sample is a left word |
| valid_right | output | 1 | One-cycle strobe: sample is a right word |

## Verification
The pattern test to run is the inverse of the payload. If an internal state is wrong, it shows on the first word emitted after the fault:

- A shift register that is one bit short or one bit long shifts the whole sample by a bit position.
- A slot counter that drifts in I2S framing picks up a padding bit as the MSB or LSB.
- A wrong channel-level register sends the sample out on the other strobe.

Each of these appears within one word-clock half period. The bench therefore checks the value and the per-channel strobe count after every stereo pair. It pads each word with patterns chosen to differ from the payload, and it disturbs the data line while the bit clock is high, so that stray bits cannot go unnoticed.

// File: rtl/sar_pkg.sv
// Package: shared configuration layout for the serial audio receiver.
// Assumes the configuration port is three bits with 20-bit select in bit 0.
package sar_pkg;
    localparam int SAR_LONG_W  = 20;
    localparam int SAR_SHORT_W = 16;
    localparam int SAR_SLOT_W  = 32;

    typedef struct packed {
        logic swap;   // bit 2: low level means left
        logic i2s;    // bit 1: I2S-style framing request
        logic res20;  // bit 0: 20-bit resolution
    } sar_cfg_t;
endpackage

// File: rtl/sar_bit_sampler.sv
// Module: registers the three serial lines in the system clock domain and
// flags each bit-clock rising edge with the data and word-clock values seen.
// Assumes the lines are already synchronous to clk and the bit clock stays
// high and low for at least one system clock each.
module sar_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic sdata,
    input  logic wclk,
    output logic bit_stb,
    output logic bit_val,
    output logic bit_wclk
);
    logic bclk_q;
    logic bclk_qq;
    logic data_q;
    logic wclk_q;

    // Capture the serial lines and keep one older bit-clock copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            bclk_qq <= 1'b0;
            data_q  <= 1'b0;
            wclk_q  <= 1'b0;
        end else begin
            bclk_q  <= bclk;
            bclk_qq <= bclk_q;
            data_q  <= sdata;
            wclk_q  <= wclk;
        end
    end

    // A rising edge is a high registered copy over a low older copy.
    always_comb begin
        bit_stb  = bclk_q & ~bclk_qq;
        bit_val  = data_q;
        bit_wclk = wclk_q;
    end

    assert_one_cycle_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);
endmodule

// File: rtl/sar_word_framer.sv
// Module: shifts received bits into a word register and hands the word on at
// each word-clock change. In I2S framing only slots 1..SHORT_W after the
// change are taken; in right-justified framing every bit is shifted, so the
// last LONG_W bits are held. Assumes at least one bit is seen before the
// first transition.
module sar_word_framer #(
    parameter int LONG_W  = 20,
    parameter int SHORT_W = 16,
    parameter int SLOT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              bit_wclk,
    input  logic              i2s_mode,
    output logic              word_done,
    output logic [LONG_W-1:0] word_bits,
    output logic              word_side,
    output logic              armed
);
    localparam int              CNT_W   = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOT_W - 1);
    localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(SHORT_W);
    localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(1);

    logic [LONG_W-1:0] shreg;
    logic              w_prev;
    logic              seen;
    logic [CNT_W-1:0]  cnt;
    logic              edge_seen;
    logic [CNT_W-1:0]  idx;
    logic              shift_en;

    // Find word-clock changes and decide whether this bit enters the word.
    always_comb begin
        edge_seen = bit_stb && seen && (bit_wclk != w_prev);
        idx       = edge_seen ? '0 : cnt;
        shift_en  = bit_stb && (!i2s_mode || ((idx >= CNT_LO) && (idx <= CNT_HI)));
    end

    // Track slot position and word-clock level, and hand completed words on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_prev    <= 1'b0;
            seen      <= 1'b0;
            cnt       <= '0;
            armed     <= 1'b0;
            word_done <= 1'b0;
            word_bits <= '0;
            word_side <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (bit_stb) begin
                seen   <= 1'b1;
                w_prev <= bit_wclk;
                cnt    <= (idx == CNT_MAX) ? idx : idx + CNT_LO;
                if (edge_seen) begin
                    armed <= 1'b1;
                    if (armed) begin
                        word_done <= 1'b1;
                        word_bits <= shreg;
                        word_side <= w_prev;
                    end
                end
            end
        end
    end

    // Shift the accepted bit in at the LSB end, MSB having arrived first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[LONG_W-2:0], bit_val};
        end
    end

    assert_i2s_tail_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && i2s_mode && !edge_seen && (cnt > CNT_HI)) |=> $stable(shreg));

    assert_done_needs_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> armed);
endmodule

// File: rtl/sar_out_fmt.sv
// Module: turns a finished word into the output sample. It takes 16 or 20
// bits, sign-extends a short word, picks the channel from the word-clock
// level and the polarity setting, and raises that channel's strobe for one
// cycle. Assumes word_done is a single-cycle pulse.
module sar_out_fmt #(
    parameter int LONG_W  = 20,
    parameter int SHORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [LONG_W-1:0] word_bits,
    input  logic              word_side,
    input  logic              res20,
    input  logic              swap,
    output logic [LONG_W-1:0] sample,
    output logic              valid_l,
    output logic              valid_r
);
    localparam int EXT_W = LONG_W - SHORT_W;

    logic [LONG_W-1:0] short_ext;
    logic              is_left;

    // Widen a short word from its top bit and resolve the channel.
    always_comb begin
        short_ext = {{EXT_W{word_bits[SHORT_W-1]}}, word_bits[SHORT_W-1:0]};
        is_left   = word_side ^ swap;
    end

    // Load the sample and pulse the matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample  <= '0;
            valid_l <= 1'b0;
            valid_r <= 1'b0;
        end else begin
            valid_l <= word_done & is_left;
            valid_r <= word_done & ~is_left;
            if (word_done) begin
                sample <= res20 ? word_bits : short_ext;
            end
        end
    end

    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_l && valid_r));

    assert_left_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_l |=> !valid_l);

    assert_right_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_r |=> !valid_r);

    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (valid_l || valid_r));

    assert_sign_extend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !res20) |=> (sample[LONG_W-1:SHORT_W] == {EXT_W{sample[SHORT_W-1]}}));
endmodule

// File: rtl/serial_audio_rx.sv
// Module: top of the serial audio receiver. It joins the bit sampler, the
// word framer and the output formatter, and works out the effective framing:
// I2S framing is only honoured in 16-bit mode.
// Assumes the serial lines are synchronous to clk and the configuration is
// held stable while a word is in flight.
module serial_audio_rx (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bclk,
    input  logic        sdata,
    input  logic        wclk,
    input  logic [2:0]  cfg,
    output logic [19:0] sample,
    output logic        valid_left,
    output logic        valid_right
);
    import sar_pkg::*;

    sar_cfg_t                cfg_s;
    logic                    i2s_eff;
    logic                    bit_stb;
    logic                    bit_val;
    logic                    bit_wclk;
    logic                    word_done;
    logic [SAR_LONG_W-1:0]   word_bits;
    logic                    word_side;
    logic                    armed;

    // Decode the configuration; 20-bit forces right-justified framing.
    always_comb begin
        cfg_s   = sar_cfg_t'(cfg);
        i2s_eff = cfg_s.i2s & ~cfg_s.res20;
    end

    sar_bit_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .sdata    (sdata),
        .wclk     (wclk),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .bit_wclk (bit_wclk)
    );

    sar_word_framer #(
        .LONG_W  (SAR_LONG_W),
        .SHORT_W (SAR_SHORT_W),
        .SLOT_W  (SAR_SLOT_W)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .bit_wclk  (bit_wclk),
        .i2s_mode  (i2s_eff),
        .word_done (word_done),
        .word_bits (word_bits),
        .word_side (word_side),
        .armed     (armed)
    );

    sar_out_fmt #(
        .LONG_W  (SAR_LONG_W),
        .SHORT_W (SAR_SHORT_W)
    ) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word_bits (word_bits),
        .word_side (word_side),
        .res20     (cfg_s.res20),
        .swap      (cfg_s.swap),
        .sample    (sample),
        .valid_l   (valid_left),
        .valid_r   (valid_right)
    );

    assert_quiet_until_armed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!valid_left && !valid_right));
endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        sdata = 1'b0;
    logic        wclk = 1'b0;
    logic [2:0]  cfg = 3'b000;
    logic [19:0] sample;
    logic        valid_left;
    logic        valid_right;

    int total = 0;
    int bad = 0;
    int n_l = 0;
    int n_r = 0;
    int overlap = 0;
    logic [19:0] got_l = '0;
    logic [19:0] got_r = '0;
    logic cur_w = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    serial_audio_rx u_serial_audio_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk        (bclk),
        .sdata       (sdata),
        .wclk        (wclk),
        .cfg         (cfg),
        .sample      (sample),
        .valid_left  (valid_left),
        .valid_right (valid_right)
    );

    // Record every emitted word, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_left)  begin n_l++; got_l = sample; end
            if (valid_right) begin n_r++; got_r = sample; end
            if (valid_left && valid_right) overlap++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bit: data set while bclk is low, disturbed while high (R9).
    task automatic send_bit(input logic w, input logic d);
        wclk = w; sdata = d; bclk = 1'b0;
        repeat (2) @(negedge clk);
        bclk = 1'b1;
        @(negedge clk);
        sdata = ~d;
        @(negedge clk);
        cur_w = w;
    endtask

    task automatic send_half(input logic w, input int start, input logic [19:0] val,
                             input bit i2s, input int n, input int len);
        for (int i = start; i < len; i++) begin
            logic d;
            if (i2s) begin
                d = (i >= 1 && i <= 16) ? val[16 - i] : i[0];
            end else begin
                int pos;
                pos = i - (len - n);
                d = (pos >= 0) ? val[n - 1 - pos] : ((i % 3) == 0);
            end
            send_bit(w, d);
        end
    endtask

    function automatic logic [19:0] expect_of(input logic [19:0] v, input int n);
        return (n == 16) ? {{4{v[15]}}, v[15:0]} : v;
    endfunction

    // Send one left/right pair, flush with a bit at the left level, check both.
    task automatic run_pair(input string tag, input logic [2:0] c, input bit i2s,
                            input int n, input int len, input logic [19:0] lv, input logic [19:0] rv);
        logic ll;
        int bl, br;
        ll = ~c[2];
        cfg = c;
        if (cur_w != ll) send_bit(ll, 1'b1);
        repeat (4) @(negedge clk);
        bl = n_l; br = n_r;
        send_half(ll, 1, lv, i2s, n, len);
        send_half(~ll, 0, rv, i2s, n, len);
        send_bit(ll, 1'b1);
        repeat (4) @(negedge clk);
        chk(got_l == expect_of(lv, n), {tag, " left R9"}, got_l, expect_of(lv, n));
        chk(got_r == expect_of(rv, n), {tag, " right"}, got_r, expect_of(rv, n));
        chk((n_l - bl) == 1, {tag, " R8 left strobe count"}, 20'(n_l - bl), 20'd1);
        chk((n_r - br) == 1, {tag, " R8 right strobe count"}, 20'(n_r - br), 20'd1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(sample == 20'h0, "R1 reset sample", sample, 20'h0);
        chk(!valid_left && !valid_right, "R1 reset strobes", {18'h0, valid_left, valid_right}, 20'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b0);
        repeat (4) @(negedge clk);
        chk((n_l + n_r) == 0, "R1 no strobe before first full word", 20'(n_l + n_r), 20'h0);
    endtask

    task automatic t_rj16();
        run_pair("R2 rj16", 3'b000, 1'b0, 16, 24, 20'h08123, 20'h07abc);
    endtask

    task automatic t_padding();
        run_pair("R4 rj16 long pad", 3'b000, 1'b0, 16, 32, 20'h00001, 20'h0ffff);
    endtask

    task automatic t_rj20();
        run_pair("R3 rj20", 3'b001, 1'b0, 20, 24, 20'h95a3c, 20'h12345);
    endtask

    task automatic t_i2s();
        run_pair("R5 i2s16", 3'b010, 1'b1, 16, 32, 20'h0c3a5, 20'h01234);
    endtask

    task automatic t_forced_rj();
        run_pair("R6 20bit with i2s bit", 3'b011, 1'b0, 20, 32, 20'ha0f0f, 20'h50f0f);
    endtask

    task automatic t_swap();
        run_pair("R7 swapped rj16", 3'b100, 1'b0, 16, 24, 20'h01111, 20'h0a222);
    endtask

    task automatic t_swap_i2s();
        run_pair("R7 swapped i2s16", 3'b110, 1'b1, 16, 32, 20'h08001, 20'h07ffe);
    endtask

    initial begin
        t_reset();
        t_rj16();
        t_padding();
        t_rj20();
        t_i2s();
        t_forced_rj();
        t_swap();
        t_swap_i2s();
        chk(overlap == 0, "R8 strobes never together", 20'(overlap), 20'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=%h expected=%h", 20'h0, 20'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule